// File: doc/BRIEF.md
# GPIO Register Bank with Set/Clear Aliases

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, grouped 32 to a word. Behind a plain 32-bit register bus (address, write strobe, write data, combinational read data), it keeps a direction register, an output-data register and a 4-bit function-select field for every pin. It also shows the synchronised level of every pad input as a read-only bank. The per-pin direction and output bits drive the pad output enable and output value directly, and the function-select nibbles go to an external pin mux.

Direction and output-data words each have three addresses in their 16-byte slot. Offset +0x0 loads the whole word. Offset +0x4 sets only the bits written as 1. Offset +0x8 clears only the bits written as 1. With the set and clear addresses, software can change one pin without a read-modify-write and without racing a second agent that owns other pins of the same word. Function-select nibbles are packed eight to a word. Pad inputs pass through a two-flop synchroniser before software can read them.

The pin count must be a multiple of 32 and at most 128. The address must be at least 11 bits wide.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted and right after it, every pad_oe bit is 0, every pad_out bit is 0, every pin_func nibble is 0, and the direction, output and mode words read back as 0.
- R2: The bank is selected by address bits [9:8]: 0 = direction (0x000), 1 = output data (0x100), 2 = input data (0x200), 3 = mode (0x300). Address bits [7:4] select the word, so word k of a bank sits at bank base + 0x10*k. Pin n uses bit n%32 of word n/32 in the direction, output and input banks.
- R3: A write at slot offset +0x0 of a direction or output word loads the whole word. A read at +0x0, +0x4 or +0x8 of that word returns the current register value.
- R4: A write at slot offset +0x4 of a direction or output word sets the bits where the write data is 1. All other bits keep their value.
- R5: A write at slot offset +0x8 of a direction or output word clears the bits where the write data is 1. All other bits keep their value.
- R6: Direction bit 1 makes a pin an output (pad_oe[n]=1), and 0 makes it an input. pad_out[n] always shows output-data bit n, whatever the direction.
- R7: Mode word m at 0x300 + 0x10*m holds eight 4-bit fields. Pin n uses word n/8, bits (n%8)*4 and up, and that field appears on pin_func[4n+3:4n]. Only offset +0x0 of a mode slot is mapped.
- R8: A read of input word k at 0x200 + 0x10*k returns pad_in bits [32k+31:32k] as they were two clock edges earlier. A change on pad_in is not visible after one edge and is visible after two.
- R9: Writes to the input bank, to unmapped offsets, to slots beyond the last word, or to addresses with any bit above bit 9 set have no effect. Reads of those unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_oe | output | NUM_PINS | Per-pin output enable (direction) |
| pad_out | output | NUM_PINS | Per-pin output value |
| pin_func | output | 4*NUM_PINS | Per-pin 4-bit function select, pin n at [4n+3:4n] |

## Verification
Direction, output and mode state is wired straight to pad_oe, pad_out and pin_func. A wrong bit caused by a bad decode or a bad set/clear merge therefore shows on those pins on the clock edge right after the offending write. It is also seen again by reading the word back at every alias offset. A fault in the input path shows up as a readback that is one cycle early or late, or that contains the wrong bits, when it is sampled after exactly one and exactly two edges. Decode faults in the ignored or unmapped space show up as pins that move, or as non-zero read data, straight after the stray access.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [4*NUM_PINS-1:0] pin_func
);

  localparam int WORDS  = NUM_PINS / 32;
  localparam int MWORDS = NUM_PINS / 8;

  logic        in_range;
  logic [1:0]  bank;
  logic [3:0]  slot;
  logic [3:0]  sub;
  logic        sub_ok;

  assign in_range = (bus_addr[ADDR_W-1:10] == '0);
  assign bank     = bus_addr[9:8];
  assign slot     = bus_addr[7:4];
  assign sub      = bus_addr[3:0];
  assign sub_ok   = (sub == 4'h0) || (sub == 4'h4) || (sub == 4'h8);

  function automatic logic [31:0] merge(input logic [31:0] cur,
                                        input logic [3:0]  op,
                                        input logic [31:0] d);
    case (op)
      4'h0:    merge = d;
      4'h4:    merge = cur | d;
      4'h8:    merge = cur & ~d;
      default: merge = cur;
    endcase
  endfunction

  logic [31:0] dir_rd  [WORDS];
  logic [31:0] dout_rd [WORDS];
  logic [31:0] din_rd  [WORDS];
  logic [31:0] mode_rd [MWORDS];

  logic [NUM_PINS-1:0] sync1, sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [31:0] dir_w, dout_w;
    logic        hit_dir, hit_dout;

    assign hit_dir  = bus_we && in_range && sub_ok && bank == 2'd0 && slot == 4'(k);
    assign hit_dout = bus_we && in_range && sub_ok && bank == 2'd1 && slot == 4'(k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_w  <= '0;
        dout_w <= '0;
      end else begin
        if (hit_dir)  dir_w  <= merge(dir_w, sub, bus_wdata);
        if (hit_dout) dout_w <= merge(dout_w, sub, bus_wdata);
      end
    end

    assign pad_oe[k*32 +: 32]  = dir_w;
    assign pad_out[k*32 +: 32] = dout_w;
    assign dir_rd[k]           = dir_w;
    assign dout_rd[k]          = dout_w;
    assign din_rd[k]           = sync2[k*32 +: 32];
  end

  for (genvar m = 0; m < MWORDS; m++) begin : g_mode
    logic [31:0] mode_w;
    logic        hit_mode;

    assign hit_mode = bus_we && in_range && sub == 4'h0 && bank == 2'd3 && slot == 4'(m);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_w <= '0;
      else if (hit_mode) mode_w <= bus_wdata;
    end

    assign pin_func[m*32 +: 32] = mode_w;
    assign mode_rd[m]           = mode_w;
  end

  always_comb begin
    bus_rdata = '0;
    if (in_range) begin
      case (bank)
        2'd0: if (sub_ok)
          for (int k = 0; k < WORDS; k++) if (slot == 4'(k)) bus_rdata = dir_rd[k];
        2'd1: if (sub_ok)
          for (int k = 0; k < WORDS; k++) if (slot == 4'(k)) bus_rdata = dout_rd[k];
        2'd2: if (sub == 4'h0)
          for (int k = 0; k < WORDS; k++) if (slot == 4'(k)) bus_rdata = din_rd[k];
        default: if (sub == 4'h0)
          for (int m = 0; m < MWORDS; m++) if (slot == 4'(m)) bus_rdata = mode_rd[m];
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [31:0]           pad_in_lo,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [4*NUM_PINS-1:0] pin_func
);

  logic [1:0] since_rst;
  logic       seen_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_ff @(posedge clk) seen_edge <= 1'b1;

  always @(negedge clk) begin
    if (seen_edge === 1'b1 && !rst_n)
      AST_RESET_CLEAR: assert (pad_oe == '0 && pad_out == '0 && pin_func == '0); // R1
  end

  AST_SET_ALIAS_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(12'h004)) |=>
      pad_oe[31:0] == ($past(pad_oe[31:0]) | $past(bus_wdata))); // R4

  AST_CLR_ALIAS_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(12'h108)) |=>
      pad_out[31:0] == ($past(pad_out[31:0]) & ~$past(bus_wdata))); // R5

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(12'h300)) |=> pin_func[31:0] == $past(bus_wdata)); // R7

  AST_INPUT_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(12'h200) && since_rst >= 2'd2) |->
      bus_rdata == $past(pad_in_lo, 2)); // R8

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:10] != '0) |-> bus_rdata == 32'h0); // R9

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pin_func))); // R9

endmodule

bind gpio_bank gpio_bank_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in_lo(pad_in[31:0]),
  .pad_oe(pad_oe), .pad_out(pad_out), .pin_func(pin_func)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out;
  logic [4*NP-1:0] pin_func;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pin_func(pin_func)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 12'h000; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pad_oe lo", pad_oe[31:0], 32'h0);
    check("R1 pad_oe hi", pad_oe[63:32], 32'h0);
    check("R1 pad_out", pad_out[31:0] | pad_out[63:32], 32'h0);
    check("R1 pin_func", pin_func[31:0] | pin_func[255:224], 32'h0);
    rd(12'h000, v); check("R1 dir read", v, 32'h0);
    rd(12'h370, v); check("R1 mode read", v, 32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] v;
    wr(12'h000, 32'hA5A5_0F0F);
    check("R6 pad_oe load", pad_oe[31:0], 32'hA5A5_0F0F);
    check("R2 word1 untouched", pad_oe[63:32], 32'h0);
    rd(12'h000, v); check("R3 read +0", v, 32'hA5A5_0F0F);
    rd(12'h004, v); check("R3 read +4", v, 32'hA5A5_0F0F);
    rd(12'h008, v); check("R3 read +8", v, 32'hA5A5_0F0F);
    wr(12'h004, 32'h0000_00F0);
    check("R4 dir set", pad_oe[31:0], 32'hA5A5_0FFF);
    wr(12'h014, 32'h8000_0001);
    check("R2 R4 word1 set", pad_oe[63:32], 32'h8000_0001);
    check("R2 word0 kept", pad_oe[31:0], 32'hA5A5_0FFF);
    wr(12'h008, 32'hFFFF_0000);
    check("R5 dir clear", pad_oe[31:0], 32'h0000_0FFF);
    wr(12'h008, 32'h0);
    check("R5 clear zero", pad_oe[31:0], 32'h0000_0FFF);
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(12'h100, 32'h1234_5678);
    check("R6 pad_out with dir 0 bits", pad_out[31:0], 32'h1234_5678);
    wr(12'h104, 32'h8000_0000);
    check("R4 dout set", pad_out[31:0], 32'h9234_5678);
    wr(12'h108, 32'h0000_0078);
    check("R5 dout clear", pad_out[31:0], 32'h9234_5600);
    wr(12'h110, 32'hDEAD_BEEF);
    check("R2 dout word1", pad_out[63:32], 32'hDEAD_BEEF);
    rd(12'h118, v); check("R3 dout read +8", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    wr(12'h300, 32'h7654_3210);
    check("R7 pin3 nibble", {28'h0, pin_func[15:12]}, 32'h3);
    check("R7 word0", pin_func[31:0], 32'h7654_3210);
    wr(12'h370, 32'hF000_0000);
    check("R7 pin63 nibble", {28'h0, pin_func[255:252]}, 32'hF);
    rd(12'h370, v); check("R7 mode read", v, 32'hF000_0000);
    wr(12'h304, 32'hFFFF_FFFF);
    check("R7 mode +4 unmapped", pin_func[31:0], 32'h7654_3210);
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk);
    pad_in = {32'h0F0F_1234, 32'hCAFE_0001};
    @(negedge clk);
    rd(12'h200, v); check("R8 one edge old", v, 32'h0);
    @(negedge clk);
    rd(12'h200, v); check("R8 two edges word0", v, 32'hCAFE_0001);
    rd(12'h210, v); check("R8 two edges word1", v, 32'h0F0F_1234);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(12'h200, 32'h1111_1111);
    rd(12'h200, v); check("R9 input write ignored", v, 32'hCAFE_0001);
    wr(12'h00C, 32'hFFFF_FFFF);
    check("R9 dir +C ignored", pad_oe[31:0], 32'h0000_0FFF);
    wr(12'h020, 32'hFFFF_FFFF);
    check("R9 slot2 ignored lo", pad_oe[31:0], 32'h0000_0FFF);
    check("R9 slot2 ignored hi", pad_oe[63:32], 32'h8000_0001);
    wr(12'h500, 32'hFFFF_FFFF);
    check("R9 high addr ignored", pad_out[31:0], 32'h9234_5600);
    rd(12'h400, v); check("R9 high read", v, 32'h0);
    rd(12'h020, v); check("R9 slot2 read", v, 32'h0);
    rd(12'h304, v); check("R9 mode +4 read", v, 32'h0);
    rd(12'h204, v); check("R9 input +4 read", v, 32'h0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_output();
    t_mode();
    t_input();
    t_ignored();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule